// File: doc/BRIEF.md
# Shared-Slave Burst Arbiter

This block decides which of several bus masters may drive one shared slave port. Every master raises a request and marks the final beat of each burst. The arbiter returns a one-hot grant. A master keeps the grant for the whole burst, so the burst length does not need to be known in advance. A configuration input chooses between two schemes: a weighted fixed-priority scheme, or a rotating scheme in which every master takes a turn.

In rotating mode, the slave can be parked on a master while no master is requesting. The parking master can be nobody, the most recently served master, or one master chosen by configuration. A parked master that starts requesting uses the grant it already holds, so it loses no cycle. A per-slave beat budget stops a long or open-ended burst. When the budget runs out, the slave is offered to the other requesters first.

Only request, burst-end, grant and configuration signals are modelled. The data path, address decoding and bus phase timing are outside this block.

Top module: `slot_arbiter`

## Requirements
- R1: `gnt` has at most one bit set. When `gnt` is zero and any `req` bit is high at a clock edge, `gnt` is non-zero after that edge.
- R2: `cfg_mode`=0 selects fixed priority. Master i's priority is `cfg_prio[i*PRIO_W +: PRIO_W]`, and a larger value wins. Among requesters with equal priority, the lowest-numbered master wins.
- R3: `cfg_mode`=1 selects rotation. The winner is the first requester found by counting upward from the most recently served master, wrapping from N_MST-1 to 0. Before any master has been served, the search starts at master 0.
- R4: A granted master that holds `req` high with `req_last` low keeps the grant on the next cycle, whatever the other requests are, unless R6 applies.
- R5: A beat with both `req` and `req_last` high ends the burst of the granted master. The slave is then re-arbitrated for the next cycle. The ending master is chosen again only if no other master is requesting.
- R6: When `cfg_slot_lim`=L is non-zero, a master keeps the grant for at most L consecutive requesting beats. After the L-th beat the slave is re-arbitrated with that master excluded, unless it is the only requester. L=0 disables the limit.
- R7: In fixed-priority mode, or in rotating mode with `cfg_park` equal to 0 or 3, `gnt` is all zeros on the cycle after a cycle with no request.
- R8: In rotating mode with `cfg_park`=1, a cycle with no request parks the grant on the most recently served master. If that master then requests, it is served with no extra cycle.
- R9: In rotating mode with `cfg_park`=2, a cycle with no request parks the grant on master `cfg_def`.
- R10: During reset and on the first cycle after reset, `gnt` is zero. With `cfg_park`=1, nobody is parked until some master has been served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | N_MST | One request line per master; held high for the whole burst |
| req_last | input | N_MST | Marks the final beat of the burst of master i |
| cfg_mode | input | 1 | 0 = fixed priority, 1 = rotation |
| cfg_park | input | 2 | Idle parking: 0 none, 1 last served, 2 fixed, 3 none |
| cfg_def | input | IDX_W | Master parked on when cfg_park is 2 |
| cfg_prio | input | N_MST*PRIO_W | Packed per-master priority values |
| cfg_slot_lim | input | SLOT_W | Beat budget per tenure; 0 means unlimited |
| gnt | output | N_MST | One-hot grant taken from registered state |

## Verification
The bench builds the arbiter with four masters, 2-bit priorities and a 4-bit beat budget. At this size, priority ties, rotation wrap-around and every parking choice occur often under pseudo-random request patterns. The bench sweeps both modes, all four parking codes and budgets of 0, 1 and 3 beats, and resets before each setting. An arithmetic model in the bench predicts the grant for every cycle and tags each prediction with the rule that produced it.

// File: rtl/slot_arbiter_pkg.sv
package slot_arbiter_pkg;

   typedef enum logic {
      ARB_FIXED = 1'b0,
      ARB_ROUND = 1'b1
   } arb_mode_e;

   typedef enum logic [1:0] {
      PARK_NONE  = 2'd0,
      PARK_LAST  = 2'd1,
      PARK_FIXED = 2'd2,
      PARK_RSVD  = 2'd3
   } park_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sa_prio_pick.sv
module sa_prio_pick #(
   parameter int N_MST  = 12,
   parameter int PRIO_W = 2,
   parameter int IDX_W  = 4
) (
   input  logic [N_MST-1:0]        cand,
   input  logic [N_MST*PRIO_W-1:0] prio,
   output logic                    valid,
   output logic [IDX_W-1:0]        idx
);
   logic [PRIO_W-1:0] best;

   // A strict comparison, scanned upward, gives ties to the lower index.
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      best  = '0;
      for (int i = 0; i < N_MST; i++) begin
         if (cand[i] && (!valid || prio[i*PRIO_W +: PRIO_W] > best)) begin
            valid = 1'b1;
            idx   = IDX_W'(i);
            best  = prio[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/sa_rr_pick.sv
module sa_rr_pick #(
   parameter int N_MST = 12,
   parameter int IDX_W = 4
) (
   input  logic [N_MST-1:0] cand,
   input  logic [IDX_W-1:0] base,
   output logic             valid,
   output logic [IDX_W-1:0] idx
);
   // The search begins one place after base, so base itself is looked at last.
   always_comb begin
      valid = 1'b0;
      idx   = '0;
      for (int k = 1; k <= N_MST; k++) begin
         int j;
         j = int'(base) + k;
         if (j >= N_MST) j = j - N_MST;
         if (!valid && cand[j]) begin
            valid = 1'b1;
            idx   = IDX_W'(j);
         end
      end
   end
endmodule

// File: rtl/sa_slot_timer.sv
module sa_slot_timer #(
   parameter int SLOT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              adv,
   input  logic [SLOT_W-1:0] limit,
   output logic              expire
);
   localparam logic [SLOT_W-1:0] CNT_MAX = '1;

   logic [SLOT_W-1:0] beats_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          beats_q <= '0;
      else if (clear)                      beats_q <= '0;
      else if (adv && beats_q != CNT_MAX)  beats_q <= beats_q + 1'b1;
   end

   // beats_q holds the beats already done, so this is true on the L-th beat.
   assign expire = (limit != '0) && (beats_q == limit - 1'b1);
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
   import slot_arbiter_pkg::*;
#(
   parameter int N_MST  = 12,
   parameter int PRIO_W = 2,
   parameter int SLOT_W = 8,
   parameter int IDX_W  = idx_width(N_MST)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_MST-1:0]        req,
   input  logic [N_MST-1:0]        req_last,
   input  logic                    cfg_mode,
   input  logic [1:0]              cfg_park,
   input  logic [IDX_W-1:0]        cfg_def,
   input  logic [N_MST*PRIO_W-1:0] cfg_prio,
   input  logic [SLOT_W-1:0]       cfg_slot_lim,
   output logic [N_MST-1:0]        gnt
);
   localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(N_MST - 1);

   if (N_MST < 2 || N_MST > 16) begin : g_bad_nmst
      $error("slot_arbiter: N_MST must be in 2..16");
   end
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("slot_arbiter: PRIO_W must be in 1..8");
   end
   if (SLOT_W < 1 || SLOT_W > 16) begin : g_bad_slot
      $error("slot_arbiter: SLOT_W must be in 1..16");
   end
   if (IDX_W < idx_width(N_MST)) begin : g_bad_idx
      $error("slot_arbiter: IDX_W too narrow for N_MST");
   end

   arb_mode_e mode;
   park_e     park;
   assign mode = arb_mode_e'(cfg_mode);
   assign park = park_e'(cfg_park);

   // Registered ownership state
   logic             own_vld_q, last_vld_q;
   logic [IDX_W-1:0] own_idx_q, last_idx_q;
   logic             own_vld_d, last_vld_d;
   logic [IDX_W-1:0] own_idx_d, last_idx_d;

   // Decode of the owner index, one bit per master
   logic [N_MST-1:0] own_oh;
   for (genvar g = 0; g < N_MST; g++) begin : g_own_dec
      assign own_oh[g] = own_vld_q && (own_idx_q == IDX_W'(g));
   end

   logic own_req, own_end, slot_exp, brk, keep;
   assign own_req = |(own_oh & req);
   assign own_end = |(own_oh & req & req_last);
   assign brk     = own_req && slot_exp;
   assign keep    = own_req && !own_end && !brk;

   // Candidate set: a master that has just finished or been cut off goes last.
   logic [N_MST-1:0] excl, cand_ex, cand;
   assign excl    = (own_end || brk) ? own_oh : '0;
   assign cand_ex = req & ~excl;
   assign cand    = (cand_ex != '0) ? cand_ex : req;

   logic             fp_vld, rr_vld;
   logic [IDX_W-1:0] fp_idx, rr_idx, rr_base;
   assign rr_base = last_vld_q ? last_idx_q : TOP_IDX;

   sa_prio_pick #(.N_MST(N_MST), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_prio (
      .cand (cand),
      .prio (cfg_prio),
      .valid(fp_vld),
      .idx  (fp_idx)
   );

   sa_rr_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_rr (
      .cand (cand),
      .base (rr_base),
      .valid(rr_vld),
      .idx  (rr_idx)
   );

   logic             win_vld;
   logic [IDX_W-1:0] win_idx;
   assign win_vld = (mode == ARB_ROUND) ? rr_vld : fp_vld;
   assign win_idx = (mode == ARB_ROUND) ? rr_idx : fp_idx;

   logic def_ok;
   assign def_ok = (cfg_def <= TOP_IDX);

   logic tmr_clr, tmr_adv;

   always_comb begin
      own_vld_d  = own_vld_q;
      own_idx_d  = own_idx_q;
      last_vld_d = last_vld_q;
      last_idx_d = last_idx_q;
      tmr_clr    = 1'b0;
      tmr_adv    = 1'b0;
      if (keep) begin
         tmr_adv    = 1'b1;
         last_vld_d = 1'b1;
         last_idx_d = own_idx_q;
      end else begin
         tmr_clr = 1'b1;
         if (win_vld) begin
            own_vld_d  = 1'b1;
            own_idx_d  = win_idx;
            last_vld_d = 1'b1;
            last_idx_d = win_idx;
         end else if (mode == ARB_ROUND && park == PARK_LAST && last_vld_q) begin
            own_vld_d = 1'b1;
            own_idx_d = last_idx_q;
         end else if (mode == ARB_ROUND && park == PARK_FIXED && def_ok) begin
            own_vld_d = 1'b1;
            own_idx_d = cfg_def;
         end else begin
            own_vld_d = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_vld_q  <= 1'b0;
         own_idx_q  <= '0;
         last_vld_q <= 1'b0;
         last_idx_q <= '0;
      end else begin
         own_vld_q  <= own_vld_d;
         own_idx_q  <= own_idx_d;
         last_vld_q <= last_vld_d;
         last_idx_q <= last_idx_d;
      end
   end

   sa_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (tmr_clr),
      .adv   (tmr_adv),
      .limit (cfg_slot_lim),
      .expire(slot_exp)
   );

   assign gnt = own_oh;
endmodule

// File: rtl/sa_arb_checker.sv
module sa_arb_checker #(
   parameter int N_MST  = 12,
   parameter int SLOT_W = 8,
   parameter int IDX_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_MST-1:0]  req,
   input logic [N_MST-1:0]  req_last,
   input logic              cfg_mode,
   input logic [1:0]        cfg_park,
   input logic [IDX_W-1:0]  cfg_def,
   input logic [SLOT_W-1:0] cfg_slot_lim,
   input logic [N_MST-1:0]  gnt
);
   localparam logic [N_MST-1:0] ONE = {{(N_MST-1){1'b0}}, 1'b1};

   p_grant_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gnt));

   p_idle_to_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (req != '0 && gnt == '0) |=> (gnt != '0));

   p_fixed_serves_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_mode == 1'b0) |=> (gnt == '0 || (gnt & $past(req)) != '0));

   p_burst_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((gnt & req & ~req_last) != '0 && cfg_slot_lim == '0) |=> $stable(gnt));

   p_idle_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0 && (cfg_mode == 1'b0 || cfg_park == 2'd0 || cfg_park == 2'd3))
      |=> (gnt == '0));

   p_park_fixed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req == '0 && cfg_mode == 1'b1 && cfg_park == 2'd2 && int'(cfg_def) < N_MST)
      |=> (gnt == (ONE << $past(cfg_def))));
endmodule

bind slot_arbiter sa_arb_checker #(
   .N_MST (N_MST),
   .SLOT_W(SLOT_W),
   .IDX_W (IDX_W)
) u_arb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req         (req),
   .req_last    (req_last),
   .cfg_mode    (cfg_mode),
   .cfg_park    (cfg_park),
   .cfg_def     (cfg_def),
   .cfg_slot_lim(cfg_slot_lim),
   .gnt         (gnt)
);

// File: tb/slot_arbiter_test.sv
module slot_arbiter_test;
   localparam int N  = 4;
   localparam int PW = 2;
   localparam int SW = 4;
   localparam int IW = 2;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n;
   logic [N-1:0]    req, req_last;
   logic            cfg_mode;
   logic [1:0]      cfg_park;
   logic [IW-1:0]   cfg_def;
   logic [N*PW-1:0] cfg_prio;
   logic [SW-1:0]   cfg_slot_lim;
   logic [N-1:0]    gnt;

   slot_arbiter #(.N_MST(N), .PRIO_W(PW), .SLOT_W(SW)) uut (
      .clk(clk), .rst_n(rst_n), .req(req), .req_last(req_last),
      .cfg_mode(cfg_mode), .cfg_park(cfg_park), .cfg_def(cfg_def),
      .cfg_prio(cfg_prio), .cfg_slot_lim(cfg_slot_lim), .gnt(gnt)
   );

   int checks = 0;
   int failures = 0;

   // Bench model of the expected ownership
   bit        m_vld, m_lstv;
   int        m_idx, m_lst, m_cnt;
   string     m_why;
   logic [N-1:0] exp_gnt;
   logic [15:0]  lfsr = 16'hACE1;

   task automatic lfsr_step();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s: gnt actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_vld = 0; m_lstv = 0; m_idx = 0; m_lst = 0; m_cnt = 0;
      exp_gnt = '0;
   endtask

   // Predicts the next grant from the current inputs and model state.
   task automatic model_step();
      bit own_req, own_end, brk;
      int lim, win, best, base;
      logic [N-1:0] cand, me;
      lim     = int'(cfg_slot_lim);
      me      = m_vld ? (N'(1) << m_idx) : '0;
      own_req = m_vld && req[m_idx];
      own_end = own_req && req_last[m_idx];
      brk     = own_req && lim != 0 && m_cnt == lim - 1;
      if (own_req && !own_end && !brk) begin
         m_cnt  = (m_cnt < 15) ? m_cnt + 1 : 15;
         m_lst  = m_idx; m_lstv = 1;
         m_why  = "R4";
      end else begin
         m_cnt = 0;
         cand  = req;
         if ((own_end || brk) && (req & ~me) != '0) cand = req & ~me;
         win = -1;
         if (cand != '0) begin
            if (cfg_mode == 1'b0) begin
               best = -1;
               for (int i = 0; i < N; i++)
                  if (cand[i] && int'(cfg_prio[i*PW +: PW]) > best) begin
                     best = int'(cfg_prio[i*PW +: PW]);
                     win  = i;
                  end
               m_why = "R2";
            end else begin
               base = m_lstv ? m_lst : N - 1;
               for (int k = 1; k <= N; k++)
                  if (win < 0 && cand[(base + k) % N]) win = (base + k) % N;
               m_why = "R3";
            end
            if (own_end) m_why = "R5";
            else if (brk) m_why = "R6";
            m_vld = 1; m_idx = win; m_lst = win; m_lstv = 1;
         end else if (cfg_mode == 1'b1 && cfg_park == 2'd1 && m_lstv) begin
            m_vld = 1; m_idx = m_lst; m_why = "R8";
         end else if (cfg_mode == 1'b1 && cfg_park == 2'd2) begin
            m_vld = 1; m_idx = int'(cfg_def); m_why = "R9";
         end else begin
            m_vld = 0;
            m_why = (cfg_mode == 1'b1 && cfg_park == 2'd1) ? "R10" : "R7";
         end
      end
      exp_gnt = m_vld ? (N'(1) << m_idx) : '0;
   endtask

   task automatic drive_random();
      logic [N-1:0] nreq, nlast;
      nreq = req;
      for (int i = 0; i < N; i++) begin
         lfsr_step();
         if (nreq[i]) begin
            if (lfsr[2:0] == 3'd0) nreq[i] = 1'b0;
         end else if (lfsr[1:0] == 2'd0) begin
            nreq[i] = 1'b1;
         end
         nlast[i] = (lfsr[6:4] == 3'd0);
      end
      req = nreq;
      req_last = nlast;
   endtask

   initial begin
      int lims[3];
      lims[0] = 0; lims[1] = 1; lims[2] = 3;
      rst_n = 1'b0; req = '0; req_last = '0;
      cfg_mode = 1'b0; cfg_park = 2'd0; cfg_def = '0; cfg_prio = '0; cfg_slot_lim = '0;
      for (int mode = 0; mode < 2; mode++) begin
         for (int pk = 0; pk < 4; pk++) begin
            for (int ls = 0; ls < 3; ls++) begin
               rst_n = 1'b0; req = '0; req_last = '0;
               cfg_mode = mode[0]; cfg_park = pk[1:0];
               cfg_slot_lim = SW'(lims[ls]);
               lfsr_step(); cfg_prio = lfsr[N*PW-1:0];
               lfsr_step(); cfg_def  = lfsr[IW-1:0];
               repeat (2) @(negedge clk);
               check("R10 in reset", gnt, '0);
               rst_n = 1'b1;
               model_reset();
               for (int c = 0; c < 250; c++) begin
                  if (c < 3) begin req = '0; req_last = '0; end
                  else drive_random();
                  model_step();
                  @(negedge clk);
                  check(m_why, gnt, exp_gnt);
                  checks++;
                  if ($countones(gnt) > 1) begin
                     failures++;
                     $display("FAIL R1: gnt actual=%b expected at most one bit set", gnt);
                  end
               end
            end
         end
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL R1 watchdog: cycles actual=200000 expected fewer");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule